// File: doc/BRIEF.md
# Time-Multiplexed Symmetric FIR Filter

This block is a single-channel, single-rate FIR filter. Its coefficients are fixed, symmetric and set at build time. The system clock runs at an integer multiple of the sample rate, so a handful of multipliers can be reused over several cycles instead of giving every tap its own multiplier.

Mirrored taps are summed before multiplication. The default length is 49 taps, which folds into 25 distinct products. A scheduler walks through those products over TDM cycles, using ceil(25 / TDM) multipliers in each cycle. The partial sums go into an accumulator, and a final register delivers exactly one full-precision result for each accepted input sample.

Upstream logic must space its input strobes at least TDM cycles apart. A strobe that lands in the middle of a schedule raises an error flag and is discarded.

Top module: `tdmfir_top`

## Requirements
- R1: While reset is held and in the cycle after it, `out_valid` is 0, `err` is 0 and `out_data` is 0.
- R2: Each result equals the exact sum over i = 0..48 of h(i)·x(n−i). Here x(n) is the newest accepted sample as signed 16-bit, and h(i) = h(48−i) = (m−12)·(3m+5) with m = min(i, 48−i). The centre tap (m = 24) is counted only once.
- R3: `out_valid` is high for exactly one cycle per accepted sample. It rises TDM clock edges after the edge that accepted the sample (default TDM = 4).
- R4: After reset the sample history is all zero. The first result after a unit impulse is therefore h(0) = −60.
- R5: An `in_valid` sampled while a schedule is running and not in its final cycle is a violation. It makes `err` high for one cycle, starting on the following edge. The sample is not stored, and it produces no result.
- R6: An `in_valid` sampled in the final cycle of a running schedule is accepted, so samples may arrive exactly every TDM cycles.
- R7: The full-scale inputs −32768 and 32767, held across the whole history, give exact results with no wraparound. `out_data` is 38 bits wide, signed.
- R8: `out_data` keeps its value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 38 | Signed full-precision result |
| err | output | 1 | Pulse marking a strobe that arrived too early |

## Verification
- **Unit impulse:** reads the coefficients back in order. This exposes a wrong mirror pairing, a centre tap counted twice, or a phase slot mapped to the wrong product.
- **Constant step and alternating-sign run:** the step tests the coefficient sum. The alternating run, fed at the tightest legal spacing, tests the sign of every other product and acceptance in the final cycle.
- **Full-scale negative and positive runs:** these expose accumulator truncation.
- **Sparse run and injected early strobes:** the sparse run checks that the output holds between results. The early strobes, with distinctive values, show whether a rejected sample leaks into the history.

// File: rtl/tdmfir_pkg.sv
package tdmfir_pkg;
  // Folded coefficient for distinct product index k (0 = outermost pair).
  function automatic int coef_of(input int k);
    return (k - 12) * (3 * k + 5);
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/tdmfir_taps.sv
module tdmfir_taps #(
  parameter int NTAPS = 49,
  parameter int DW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift,
  input  logic [DW-1:0]              din,
  output logic [NTAPS-1:0][DW-1:0]   taps
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (shift) begin
      taps <= {taps[NTAPS-2:0], din};
    end
  end
endmodule

// File: rtl/tdmfir_sched.sv
module tdmfir_sched #(
  parameter int TDM = 4,
  parameter int PHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           accept,
  output logic           early,
  output logic           busy,
  output logic           last,
  output logic [PHW-1:0] phase
);
  assign last   = busy && (phase == PHW'(TDM - 1));
  assign accept = in_valid && (!busy || last);
  assign early  = in_valid && busy && !last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      phase <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/tdmfir_mac.sv
module tdmfir_mac
  import tdmfir_pkg::*;
#(
  parameter int NTAPS = 49,
  parameter int TDM   = 4,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int AW    = 38,
  parameter int PHW   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NTAPS-1:0][DW-1:0] taps,
  input  logic                     busy,
  input  logic                     last,
  input  logic [PHW-1:0]           phase,
  output logic                     out_valid,
  output logic [AW-1:0]            out_data
);
  localparam int  NPAIR = (NTAPS + 1) / 2;
  localparam int  NMUL  = ceil_div(NPAIR, TDM);
  localparam bit  ODD   = (NTAPS % 2) == 1;
  localparam int  PRW   = DW + 1 + CW;

  // Pre-add mirrored taps; the centre tap of an odd length stands alone.
  function automatic logic signed [DW:0] fold(input logic [NTAPS-1:0][DW-1:0] t,
                                              input int k);
    logic signed [DW:0] a, b;
    a = {t[k][DW-1], t[k]};
    if (ODD && k == NPAIR - 1) b = '0;
    else                       b = {t[NTAPS-1-k][DW-1], t[NTAPS-1-k]};
    return a + b;
  endfunction

  logic signed [PRW-1:0] prod [NMUL];
  logic signed [AW-1:0]  partial;
  logic signed [AW-1:0]  acc_q;
  logic signed [AW-1:0]  acc_next;

  for (genvar m = 0; m < NMUL; m++) begin : g_mul
    logic signed [DW:0]   pre;
    logic signed [CW-1:0] cf;
    always_comb begin
      pre = '0;
      cf  = '0;
      for (int p = 0; p < TDM; p++) begin
        if (int'(phase) == p && (p * NMUL + m) < NPAIR) begin
          pre = fold(taps, p * NMUL + m);
          cf  = CW'(coef_of(p * NMUL + m));
        end
      end
    end
    assign prod[m] = pre * cf;
  end

  always_comb begin
    partial = '0;
    for (int m = 0; m < NMUL; m++) partial = partial + AW'(prod[m]);
  end

  assign acc_next = ((phase == '0) ? '0 : acc_q) + partial;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= last;
      if (busy) acc_q <= acc_next;
      if (last) out_data <= acc_next;
    end
  end
endmodule

// File: rtl/tdmfir_top.sv
module tdmfir_top #(
  parameter int NTAPS = 49,
  parameter int TDM   = 4,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int AW    = DW + 1 + CW + $clog2((NTAPS + 1) / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [AW-1:0] out_data,
  output logic          err
);
  localparam int PHW = (TDM > 1) ? $clog2(TDM) : 1;

  logic                     accept, early, busy, last;
  logic [PHW-1:0]           phase;
  logic [NTAPS-1:0][DW-1:0] taps;

  tdmfir_sched #(.TDM(TDM), .PHW(PHW)) u_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .accept(accept), .early(early), .busy(busy), .last(last), .phase(phase)
  );

  tdmfir_taps #(.NTAPS(NTAPS), .DW(DW)) u_taps (
    .clk(clk), .rst_n(rst_n), .shift(accept), .din(in_data), .taps(taps)
  );

  tdmfir_mac #(.NTAPS(NTAPS), .TDM(TDM), .DW(DW), .CW(CW), .AW(AW), .PHW(PHW)) u_mac (
    .clk(clk), .rst_n(rst_n), .taps(taps), .busy(busy), .last(last), .phase(phase),
    .out_valid(out_valid), .out_data(out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= early;
  end
endmodule

// File: rtl/tdmfir_chk.sv
module tdmfir_chk #(
  parameter int AW  = 38,
  parameter int PHW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           accept,
  input logic           early,
  input logic           busy,
  input logic           last,
  input logic [PHW-1:0] phase,
  input logic           out_valid,
  input logic [AW-1:0]  out_data,
  input logic           err
);
  p_out_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy && last));

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(early));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  p_accept_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && phase == '0));
endmodule

bind tdmfir_top tdmfir_chk #(.AW(AW), .PHW(PHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .early(early), .busy(busy),
  .last(last), .phase(phase), .out_valid(out_valid), .out_data(out_data), .err(err)
);

// File: tb/tb_tdmfir_top.sv
module tb_tdmfir_top;
  localparam int NT  = 49;
  localparam int TDM = 4;
  localparam int DW  = 16;
  localparam int AW  = 38;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, err;
  logic [AW-1:0] out_data;

  tdmfir_top dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
                  .out_valid(out_valid), .out_data(out_data), .err(err));

  always #4 clk = ~clk;

  typedef struct { longint data; int cyc; string tag; } exp_t;
  exp_t   q[$];
  int     errq[$];
  longint hist [NT];
  int     cnt = 0, checks = 0, fails = 0;
  longint last_out = 0;
  bit     done = 0;

  always @(posedge clk) cnt <= cnt + 1;

  function automatic longint h(input int i);
    int m;
    m = (i <= NT - 1 - i) ? i : NT - 1 - i;
    return longint'((m - 12) * (3 * m + 5));
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Caller sits at a negedge; strobe lasts one cycle, next strobe 'gap' cycles later.
  task automatic send(input int x, input int gap, input string tag);
    longint s;
    exp_t e;
    for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = longint'($signed(x[DW-1:0]));
    s = 0;
    for (int i = 0; i < NT; i++) s += h(i) * hist[i];
    e.data = s; e.cyc = cnt + 1 + TDM; e.tag = tag;
    q.push_back(e);
    in_valid = 1; in_data = x[DW-1:0];
    @(negedge clk);
    in_valid = 0;
    repeat (gap - 1) @(negedge clk);
  endtask

  // Legal sample followed one cycle later by an early strobe (R5).
  task automatic send_violation(input int x, input int bad);
    send(x, 1, "R5");
    errq.push_back(cnt + 1);
    in_valid = 1; in_data = bad[DW-1:0];
    @(negedge clk);
    in_valid = 0;
    repeat (TDM - 2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) check(0, "R3 unexpected out_valid", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(longint'($signed(out_data)) == e.data, e.tag, longint'($signed(out_data)), e.data);
          check(cnt == e.cyc, "R3 latency", cnt, e.cyc);
        end
        last_out = longint'($signed(out_data));
      end else if (longint'($signed(out_data)) != last_out) begin
        check(0, "R8 hold", longint'($signed(out_data)), last_out);
      end
      if (err) begin
        if (errq.size() == 0) check(0, "R5 unexpected err", 1, 0);
        else begin
          int c;
          c = errq.pop_front();
          check(cnt == c, "R5 err timing", cnt, c);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && err == 0 && out_data == '0, "R1 reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && err == 0 && out_data == '0, "R1 after reset", out_data, 0);
    send(1, TDM, "R4");
    for (int i = 0; i < 50; i++) send(0, TDM, "R2");
    for (int i = 0; i < 60; i++) send(100, TDM + 1, "R2");
    for (int i = 0; i < 30; i++) send((i % 2) ? -1234 : 1234, TDM, "R6");
    for (int i = 0; i < 55; i++) send(-32768, TDM, "R7");
    for (int i = 0; i < 55; i++) send(32767, TDM, "R7");
    send_violation(17, 5000);
    for (int i = 0; i < 3; i++) send(i * 311 - 400, TDM, "R5");
    send_violation(-222, -9000);
    send_violation(999, 7777);
    for (int i = 0; i < 20; i++) send(i * 97 - 900, 9, "R8");
    repeat (3 * TDM + 5) @(negedge clk);
    check(q.size() == 0, "R3 missing outputs", q.size(), 0);
    check(errq.size() == 0, "R5 missing err", errq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule